// File: doc/BRIEF.md
# Page Load Buffer and Word Address Counter

This block sits behind a serial bus engine in front of a 4K-byte nonvolatile-style memory. It keeps the word address counter and a one-page load buffer. It models the self-timed programming of that memory. The bus engine sends four single-cycle commands:
- load a new address;
- place a data byte in the buffer;
- step the counter after a read;
- commit the buffered page.

The memory is a plain behavioural array inside the block. Its byte at the current address is always visible on a read port.

The memory is split into 128 pages of 32 bytes. Address bits 11..5 pick the page and bits 4..0 pick the byte. Each buffered byte advances only the byte field, so a burst of writes cycles inside one page. If a burst is longer than a page, it overwrites slots it already filled. Read stepping moves across the whole array and wraps from the top address back to zero.

On commit, the slots marked as loaded are copied into the page of the most recent write, one slot per cycle. A busy flag covers a programmable number of cycles, standing in for the multi-millisecond programming time. All commands are ignored while it is high.

Top module: `page_load_unit`

## Requirements
- R1: After reset, `curAddr` is 0x000, `busy` is 0 and no buffer slot is marked as loaded.
- R2: With `busy` low, `loadAddrEn` makes `curAddr` equal `loadAddr` from the next clock edge on.
- R3: With `busy` low, `wrEn` stores `wrData` in buffer slot `curAddr[4:0]` and marks that slot. It then sets `curAddr[4:0]` to the old value plus one, wrapping 31 to 0, and leaves `curAddr[11:5]` unchanged. For example, 0x1FF becomes 0x1E0.
- R4: A burst of 32 writes that starts at byte 16 of a page fills bytes 16..31 and then 0..15 of that page. It leaves `curAddr` back at byte 16 of the same page.
- R5: In a burst longer than 32 bytes, a later byte that lands on an already loaded slot replaces the earlier byte, and only the last value reaches memory.
- R6: With `busy` low, `rdAdvance` adds one to the full 12-bit `curAddr`, wrapping 0xFFF to 0x000. `rdData` always shows the memory byte at `curAddr` in the same cycle.
- R7: With `busy` low and at least one slot marked, `commitEn` raises `busy` from the next edge. `busy` then stays high for exactly `WRITE_CYCLES` cycles, or 32 if `WRITE_CYCLES` is smaller. When it falls, every marked slot has been written to its byte in the page of the most recent write. Unmarked bytes of that page keep their old contents.
- R8: `commitEn` with no slot marked is ignored: `busy` stays low.
- R9: While `busy` is high, all four commands are ignored. `curAddr` does not change, and no byte is buffered or marked.
- R10: All loaded marks clear when a commit finishes, so a following commit with no new writes is ignored.
- R11: When several commands arrive in one idle cycle, only one acts. The order of precedence is: commit (when a slot is marked), then address load, then byte write, then read step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadAddrEn | input | 1 | Load `loadAddr` into the address counter |
| loadAddr | input | 12 | New word address |
| wrEn | input | 1 | Buffer `wrData` at the current byte slot and step inside the page |
| wrData | input | 8 | Byte to buffer |
| rdAdvance | input | 1 | Step the address counter across the whole array |
| commitEn | input | 1 | Start the timed write of the loaded slots |
| curAddr | output | 12 | Current word address counter |
| rdData | output | 8 | Memory byte at `curAddr` |
| busy | output | 1 | Timed write in progress |

## Verification
The bench aims at four corner cases:
- **Burst starting mid-page.** A 32-byte burst starting at byte 16 must split across the page end. A design that carried into the page field would scatter bytes into the next page and leave the counter one page too high.
- **Overlong burst.** The 34-byte burst checks that the last value wins. Write-once slots would leave stale data in memory.
- **Partial commit.** A two-byte commit over a fully written page checks that unmarked bytes survive, which catches a design that writes the whole buffer.
- **Counter edges and the busy window.** Read stepping across 0xFFF, plus precedence among commands arriving together, catch wrong wrap and arbitration. Commands sent during the busy window, and a repeated commit with no new writes, expose a design that listens while busy or never clears its marks.

// File: rtl/plu_pkg.sv
package plu_pkg;
  typedef struct packed {
    logic startWrite;
    logic setAddr;
    logic putByte;
    logic stepRead;
    logic memWe;
    logic clearMarks;
  } plu_strobes_t;
endpackage

// File: rtl/plu_ctrl.sv
module plu_ctrl
  import plu_pkg::*;
#(
  parameter int BYTE_W = 5,
  parameter int HOLD   = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadAddrEn,
  input  logic              wrEn,
  input  logic              rdAdvance,
  input  logic              commitEn,
  input  logic              anyMarked,
  output plu_strobes_t      strb,
  output logic [BYTE_W-1:0] memIdx,
  output logic              busy
);
  localparam int PAGE  = 1 << BYTE_W;
  localparam int CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] stepCnt;
  logic             lastStep;

  assign lastStep = (stepCnt == CNT_W'(HOLD - 1));
  assign memIdx   = stepCnt[BYTE_W-1:0];

  always_comb begin
    strb = '0;
    if (!busy) begin
      if (commitEn && anyMarked) strb.startWrite = 1'b1;
      else if (loadAddrEn)       strb.setAddr    = 1'b1;
      else if (wrEn)             strb.putByte    = 1'b1;
      else if (rdAdvance)        strb.stepRead   = 1'b1;
    end else begin
      strb.memWe      = (stepCnt < CNT_W'(PAGE));
      strb.clearMarks = lastStep;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
    end else if (busy) begin
      if (lastStep) begin
        busy    <= 1'b0;
        stepCnt <= '0;
      end else begin
        stepCnt <= stepCnt + CNT_W'(1);
      end
    end else if (strb.startWrite) begin
      busy    <= 1'b1;
      stepCnt <= '0;
    end
  end
endmodule

// File: rtl/plu_datapath.sv
module plu_datapath
  import plu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  plu_strobes_t      strb,
  input  logic [BYTE_W-1:0] memIdx,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              anyMarked
);
  localparam int PAGE_W = ADDR_W - BYTE_W;
  localparam int PAGE   = 1 << BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [PAGE_W-1:0] wrPage;
  logic [PAGE-1:0]   marks;
  logic [DATA_W-1:0] slots [PAGE];
  logic [DATA_W-1:0] mem   [DEPTH];
  logic [BYTE_W-1:0] byteNext;

  assign byteNext = curAddr[BYTE_W-1:0] + BYTE_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      wrPage  <= '0;
    end else if (strb.setAddr) begin
      curAddr <= loadAddr;
    end else if (strb.putByte) begin
      curAddr <= {curAddr[ADDR_W-1:BYTE_W], byteNext};
      wrPage  <= curAddr[ADDR_W-1:BYTE_W];
    end else if (strb.stepRead) begin
      curAddr <= curAddr + ADDR_W'(1);
    end
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    logic              markQ;
    logic [DATA_W-1:0] slotQ;
    logic              hit;
    assign hit = strb.putByte && (curAddr[BYTE_W-1:0] == BYTE_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        markQ <= 1'b0;
        slotQ <= '0;
      end else if (strb.clearMarks) begin
        markQ <= 1'b0;
      end else if (hit) begin
        markQ <= 1'b1;
        slotQ <= wrData;
      end
    end
    assign marks[g] = markQ;
    assign slots[g] = slotQ;
  end

  always_ff @(posedge clk) begin
    if (strb.memWe && marks[memIdx])
      mem[{wrPage, memIdx}] <= slots[memIdx];
  end

  assign rdData    = mem[curAddr];
  assign anyMarked = |marks;
endmodule

// File: rtl/page_load_unit.sv
module page_load_unit
  import plu_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int BYTE_W       = 5,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadAddrEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdAdvance,
  input  logic              commitEn,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy
);
  localparam int PAGE = 1 << BYTE_W;
  localparam int HOLD = (WRITE_CYCLES < PAGE) ? PAGE : WRITE_CYCLES;

  plu_strobes_t      strb;
  logic [BYTE_W-1:0] memIdx;
  logic              anyMarked;

  plu_ctrl #(.BYTE_W(BYTE_W), .HOLD(HOLD)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadAddrEn(loadAddrEn), .wrEn(wrEn),
    .rdAdvance(rdAdvance), .commitEn(commitEn), .anyMarked(anyMarked),
    .strb(strb), .memIdx(memIdx), .busy(busy)
  );

  plu_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memIdx(memIdx),
    .loadAddr(loadAddr), .wrData(wrData), .curAddr(curAddr),
    .rdData(rdData), .anyMarked(anyMarked)
  );
endmodule

// File: rtl/plu_checker.sv
module plu_checker #(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 5,
  parameter int HOLD   = 5000
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadAddrEn,
  input logic [ADDR_W-1:0] loadAddr,
  input logic              wrEn,
  input logic              rdAdvance,
  input logic              commitEn,
  input logic [ADDR_W-1:0] curAddr,
  input logic              busy
);
  localparam int RUN_W = $clog2(HOLD + 2);
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + RUN_W'(1);
    else           runLen <= '0;
  end

  a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> $stable(curAddr));

  a_r7_busy_from_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(commitEn));

  a_r7_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == RUN_W'(HOLD)));

  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    $past(!busy && loadAddrEn && !commitEn) |-> (curAddr == $past(loadAddr)));

  a_r3_write_in_page: assert property (@(posedge clk) disable iff (!rstN)
    $past(!busy && wrEn && !loadAddrEn && !commitEn) |->
      (curAddr[ADDR_W-1:BYTE_W] == $past(curAddr[ADDR_W-1:BYTE_W])) &&
      (curAddr[BYTE_W-1:0] == $past(curAddr[BYTE_W-1:0]) + BYTE_W'(1)));

  a_r6_read_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(!busy && rdAdvance && !wrEn && !loadAddrEn && !commitEn) |->
      (curAddr == $past(curAddr) + ADDR_W'(1)));
endmodule

bind page_load_unit plu_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .HOLD(HOLD)) u_plu_checker (
  .clk(clk), .rstN(rstN), .loadAddrEn(loadAddrEn), .loadAddr(loadAddr),
  .wrEn(wrEn), .rdAdvance(rdAdvance), .commitEn(commitEn),
  .curAddr(curAddr), .busy(busy)
);

// File: tb/test_page_load_unit.sv
module test_page_load_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WCYC = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadAddrEn = 1'b0;
  logic [11:0] loadAddr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdAdvance = 1'b0;
  logic        commitEn = 1'b0;
  logic [11:0] curAddr;
  logic [7:0]  rdData;
  logic        busy;

  int total = 0;
  int bad = 0;

  logic [11:0] mAddr;
  logic [6:0]  mPage;
  logic [7:0]  mBuf  [32];
  bit          mMark [32];
  logic [7:0]  mMem  [4096];
  bit          mKnown[4096];

  page_load_unit #(.WRITE_CYCLES(WCYC)) i_page_load_unit (
    .clk(clk), .rstN(rstN), .loadAddrEn(loadAddrEn), .loadAddr(loadAddr),
    .wrEn(wrEn), .wrData(wrData), .rdAdvance(rdAdvance), .commitEn(commitEn),
    .curAddr(curAddr), .rdData(rdData), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doLoad(logic [11:0] a);
    loadAddrEn = 1'b1; loadAddr = a;
    @(negedge clk);
    loadAddrEn = 1'b0;
    mAddr = a;
  endtask

  task automatic doWrite(logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    mBuf[mAddr[4:0]] = d;
    mMark[mAddr[4:0]] = 1'b1;
    mPage = mAddr[11:5];
    mAddr = {mAddr[11:5], mAddr[4:0] + 5'd1};
  endtask

  task automatic doStep();
    rdAdvance = 1'b1;
    @(negedge clk);
    rdAdvance = 1'b0;
    mAddr = mAddr + 12'd1;
  endtask

  function automatic bit anyMark();
    for (int i = 0; i < 32; i++) if (mMark[i]) return 1'b1;
    return 1'b0;
  endfunction

  // commit and, when expected, measure the busy window
  task automatic doCommit(string tag);
    bit exp;
    int cnt;
    exp = anyMark();
    commitEn = 1'b1;
    @(negedge clk);
    commitEn = 1'b0;
    check({tag, " busy after commit"}, 32'(busy), 32'(exp));
    if (exp && busy) begin
      cnt = 0;
      while (busy && cnt < WCYC + 10) begin
        cnt++;
        @(negedge clk);
      end
      check({tag, " busy length R7"}, cnt, WCYC);
      for (int i = 0; i < 32; i++) begin
        if (mMark[i]) begin
          mMem[{mPage, 5'(i)}] = mBuf[i];
          mKnown[{mPage, 5'(i)}] = 1'b1;
          mMark[i] = 1'b0;
        end
      end
    end
  endtask

  task automatic checkRead(logic [11:0] a, string tag);
    doLoad(a);
    if (mKnown[a]) check({tag, " rdData"}, 32'(rdData), 32'(mMem[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] hold;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 32; i++) mMark[i] = 1'b0;
    for (int i = 0; i < 4096; i++) mKnown[i] = 1'b0;
    mAddr = '0; mPage = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 curAddr", 32'(curAddr), 0);
    check("R1 busy", 32'(busy), 0);
    doCommit("R8 R1 no marks after reset");

    doLoad(12'h0F0);
    check("R2 curAddr", 32'(curAddr), 32'h0F0);

    // full page 7
    doLoad(12'h0E0);
    for (int i = 0; i < 32; i++) doWrite(8'(8'h10 + i));
    check("R3 full page counter", 32'(curAddr), 32'h0E0);
    doCommit("R7 full page");
    for (int i = 0; i < 32; i++) checkRead(12'(12'h0E0 + i), "R7 full page");

    // mid-page start
    doLoad(12'h0F0);
    for (int i = 0; i < 32; i++) doWrite(8'(8'hA0 + i));
    check("R4 counter back at byte 16", 32'(curAddr), 32'h0F0);
    doCommit("R4 split burst");
    checkRead(12'h0F0, "R4 first byte");
    check("R4 byte16", 32'(rdData), 32'hA0);
    checkRead(12'h0E0, "R4 wrapped byte");
    check("R4 byte0", 32'(rdData), 32'hB0);
    for (int i = 0; i < 32; i++) checkRead(12'(12'h0E0 + i), "R4 page");

    // overlong burst
    doLoad(12'h105);
    for (int i = 0; i < 34; i++) doWrite(8'(8'h40 + i));
    doCommit("R5 overlong");
    checkRead(12'h105, "R5 overwritten slot");
    check("R5 last value", 32'(rdData), 32'h60);
    checkRead(12'h106, "R5 overwritten slot2");
    checkRead(12'h107, "R5 single slot");

    // partial commit over full page
    doLoad(12'h0E3);
    doWrite(8'h5A); doWrite(8'hC3);
    doCommit("R7 partial");
    for (int i = 0; i < 32; i++) checkRead(12'(12'h0E0 + i), "R7 unmarked kept");

    // in-page wrap
    doLoad(12'h1FF);
    doWrite(8'h77);
    check("R3 wrap 0x1FF", 32'(curAddr), 32'h1E0);
    doCommit("R3 commit");
    checkRead(12'h1FF, "R3 stored");

    // read stepping
    doLoad(12'hFFE);
    doStep();
    check("R6 step", 32'(curAddr), 32'hFFF);
    doStep();
    check("R6 wrap", 32'(curAddr), 32'h000);
    doLoad(12'h0E0);
    for (int i = 0; i < 32; i++) begin
      check("R6 rdData", 32'(rdData), 32'(mMem[mAddr]));
      doStep();
    end
    check("R6 page cross", 32'(curAddr), 32'h100);

    // marks clear after commit
    doLoad(12'h300);
    doWrite(8'h11);
    doCommit("R10 first");
    doCommit("R10 second ignored");

    // commands while busy
    doLoad(12'h320);
    doWrite(8'h22);
    hold = mAddr;
    commitEn = 1'b1;
    @(negedge clk);
    commitEn = 1'b0;
    check("R9 busy raised", 32'(busy), 1);
    loadAddrEn = 1'b1; loadAddr = 12'h555; wrEn = 1'b1; wrData = 8'h99; rdAdvance = 1'b1;
    repeat (5) @(negedge clk);
    loadAddrEn = 1'b0; wrEn = 1'b0; rdAdvance = 1'b0;
    while (busy) @(negedge clk);
    check("R9 curAddr frozen", 32'(curAddr), 32'(hold));
    mMem[12'h320] = 8'h22; mKnown[12'h320] = 1'b1;
    for (int i = 0; i < 32; i++) mMark[i] = 1'b0;
    doCommit("R9 nothing buffered while busy");
    checkRead(12'h320, "R9 stored byte");

    // precedence
    doLoad(12'h21F);
    loadAddrEn = 1'b1; loadAddr = 12'h444; wrEn = 1'b1; rdAdvance = 1'b1;
    @(negedge clk);
    loadAddrEn = 1'b0; wrEn = 1'b0; rdAdvance = 1'b0;
    mAddr = 12'h444;
    check("R11 load wins", 32'(curAddr), 32'h444);
    doCommit("R11 write lost to load");
    doLoad(12'h21F);
    wrEn = 1'b1; wrData = 8'h3C; rdAdvance = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdAdvance = 1'b0;
    mBuf[5'd31] = 8'h3C; mMark[31] = 1'b1; mPage = 7'h10; mAddr = 12'h200;
    check("R11 write beats step", 32'(curAddr), 32'h200);
    doCommit("R11 commit");
    checkRead(12'h21F, "R11 stored");

    // random bursts
    for (int it = 0; it < 20; it++) begin
      logic [11:0] base;
      int n;
      base = 12'($urandom_range(0, 4095));
      n = $urandom_range(1, 40);
      doLoad(base);
      for (int k = 0; k < n; k++) doWrite(8'($urandom));
      check("R3 random counter", 32'(curAddr), 32'(mAddr));
      doCommit("R7 random");
      for (int k = 0; k < 8; k++)
        checkRead({base[11:5], 5'($urandom_range(0, 31))}, "R5 random readback");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule